// File: doc/BRIEF.md
# Timer Update Event Controller

This block is the counting core of a general-purpose timer. A prescaler divides the system clock by a programmable ratio. An up/down counter then steps between zero and a reload limit. Wrapping past the limit in either direction raises an update. The block also accepts two other update causes: a one-cycle software strobe and a restart pulse from a neighbouring slave-mode controller. It combines the three causes into a single update event strobe, a sticky interrupt flag and a one-cycle DMA request.

Two control bits filter the update path. The suppress bit blocks every update event. Even then, a software strobe or a slave restart still reinitialises the counter and the prescaler. The overflow-only bit lets only a counter wrap raise the interrupt flag or the DMA request. Software and slave updates then still pulse the update event, but they raise no request. With the one-shot bit set, the first update event clears the enable bit, so the counter halts where the update left it.

Top module: `tmr_update_ctrl`

## Requirements
- R1: After reset the count is 0, and the enable bit, update strobe, interrupt flag and DMA request are all 0.
- R2: With `dir_down`=0, each prescaler tick raises the count by one. A tick at `reload` wraps the count to 0, and that wrap is an overflow. Ticks come every `psc_div`+1 enabled cycles.
- R3: With `dir_down`=1, each tick lowers the count by one. A tick at 0 reloads `reload`, and that reload is an underflow.
- R4: With `upd_suppress`=0, a wrap, a `sw_ug` pulse or a `slv_restart` pulse produces a one-cycle `upd_evt`. It appears on the clock edge that acts on that cause.
- R5: With `upd_suppress`=1, no cause produces `upd_evt`, `dma_req` or a set of `irq_flag`.
- R6: A `sw_ug` or `slv_restart` pulse always reinitialises, whatever `upd_suppress` is. The count loads 0 when counting up or `reload` when counting down, and the prescaler restarts its division from zero. Reinitialisation takes priority over a tick in the same cycle.
- R7: With `req_ovf_only`=0, every update event sets `irq_flag` and pulses `dma_req`. With `req_ovf_only`=1, only a counter wrap does so.
- R8: `irq_flag` stays set until `irq_clr` is pulsed. A new request in the same cycle as `irq_clr` wins, and the flag stays set.
- R9: `dma_req` is high for exactly one cycle for each requesting update event.
- R10: With `one_shot`=1, an update event clears the enable bit on the same edge, and the count then holds.
- R11: `en_clr` clears the enable bit and `en_set` sets it. A clear, from software or from one-shot hardware, wins over a set.
- R12: While the enable bit is 0, the count holds. A `sw_ug` pulse still reinitialises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_set | input | 1 | Pulse: set the timer enable bit |
| en_clr | input | 1 | Pulse: clear the timer enable bit |
| dir_down | input | 1 | Count direction, 0 up, 1 down |
| reload | input | CNT_W | Counter limit |
| psc_div | input | PSC_W | Prescaler ratio minus one |
| upd_suppress | input | 1 | 1 blocks all update events |
| req_ovf_only | input | 1 | 1 lets only counter wraps raise requests |
| one_shot | input | 1 | 1 stops the timer at the next update event |
| sw_ug | input | 1 | One-cycle software update-generate strobe |
| slv_restart | input | 1 | One-cycle restart from slave-mode logic |
| irq_clr | input | 1 | Pulse: clear the interrupt flag |
| timer_en | output | 1 | Timer enable bit |
| count | output | CNT_W | Current counter value |
| upd_evt | output | 1 | One-cycle update event strobe |
| irq_flag | output | 1 | Sticky update interrupt flag |
| dma_req | output | 1 | One-cycle update DMA request |

## Verification
A bad prescaler phase shows up as a count step that is early or late. It becomes visible within psc_div+1 cycles of the next tick, so the bench checks the count on both sides of each expected tick. A counter or wrap-detect fault changes `count` on the very next edge, and it misplaces `upd_evt` and `dma_req` in the wrap cycle. A gating fault in the update path shows on the edge right after the cause. The symptom is an event or request that should be absent, or an `irq_flag` that fails to set or fails to stick. A bad enable state shows as a count that moves or freezes against expectation.

// File: rtl/tmr_upd_pkg.sv
// Shared types for the timer update event controller.
package tmr_upd_pkg;

    // Counting direction selected by the direction input.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    // The three causes of an update event, gathered in one cycle.
    typedef struct packed {
        logic wrap;     // counter overflow or underflow
        logic sw;       // software update-generate strobe
        logic slv;      // slave-mode restart
    } upd_src_t;

endpackage

// File: rtl/tmr_psc.sv
// Clock prescaler. While run_i is high it counts enabled cycles from 0 up to
// div_i and emits one tick per div_i+1 cycles. A reinit forces the phase
// back to zero and masks the tick of that cycle.
// Assumes div_i is held stable while running.
module tmr_psc #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             reinit_i,
    input  logic [PSC_W-1:0] div_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] phase_q;

    // Tick when the phase reaches the ratio, unless a reinit overrides it.
    assign tick_o = run_i && !reinit_i && (phase_q == div_i);

    // Advance the phase; wrap on tick; clear on reset or reinit.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase_q <= '0;
        else if (reinit_i)  phase_q <= '0;
        else if (tick_o)    phase_q <= '0;
        else if (run_i)     phase_q <= phase_q + 1'b1;
    end

    // R6
    psc_reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_i |=> (phase_q == '0));

    // R12
    psc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !reinit_i) |=> $stable(phase_q));
endmodule

// File: rtl/tmr_cnt.sv
// Up/down counter between 0 and a reload limit. It steps on each prescaler
// tick and reports a wrap (overflow or underflow) in the cycle of the tick.
// A reinit loads the start value for the current direction and wins over a
// tick. Assumes the tick is already masked during reinit.
module tmr_cnt
    import tmr_upd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             reinit_i,
    input  cnt_dir_e         dir_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_limit;
    logic [CNT_W-1:0] start_val;

    // The limit is the reload value counting up, or zero counting down.
    assign at_limit  = (dir_i == DIR_DOWN) ? (cnt_q == '0) : (cnt_q == reload_i);
    // The value loaded on a wrap or a reinit.
    assign start_val = (dir_i == DIR_DOWN) ? reload_i : '0;
    assign wrap_o    = tick_i && at_limit;
    assign cnt_o     = cnt_q;

    // Count register: reinit first, then wrap, then a single step.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (reinit_i)          cnt_q <= start_val;
        else if (wrap_o)            cnt_q <= start_val;
        else if (tick_i) begin
            if (dir_i == DIR_DOWN)  cnt_q <= cnt_q - 1'b1;
            else                    cnt_q <= cnt_q + 1'b1;
        end
    end

    // R12
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !reinit_i) |=> $stable(cnt_q));

    // R2
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && dir_i == DIR_UP) |=> (cnt_q == '0));

    // R3
    down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && dir_i == DIR_DOWN) |=> (cnt_q == $past(reload_i)));
endmodule

// File: rtl/tmr_upd_gen.sv
// Update event generator. It merges the three update causes, applies the
// suppress and overflow-only filters, and registers the event strobe, the
// DMA pulse and the sticky interrupt flag. It also drives the reinit request,
// which stays active while events are suppressed.
module tmr_upd_gen
    import tmr_upd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  upd_src_t src_i,
    input  logic     suppress_i,
    input  logic     ovf_only_i,
    input  logic     irq_clr_i,
    output logic     upd_now_o,
    output logic     reinit_o,
    output logic     upd_evt_o,
    output logic     irq_o,
    output logic     dma_o
);
    logic req_now;
    logic evt_q, irq_q, dma_q;

    // Software and slave causes always reinitialise.
    assign reinit_o  = src_i.sw || src_i.slv;
    // An update event exists only when not suppressed.
    assign upd_now_o = !suppress_i && (src_i.wrap || reinit_o);
    // A request needs an event and, in overflow-only mode, a wrap.
    assign req_now   = upd_now_o && (src_i.wrap || !ovf_only_i);

    // Register the event strobe and the DMA pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
            dma_q <= 1'b0;
        end else begin
            evt_q <= upd_now_o;
            dma_q <= req_now;
        end
    end

    // Sticky interrupt flag: a new request wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (req_now)   irq_q <= 1'b1;
        else if (irq_clr_i) irq_q <= 1'b0;
    end

    assign upd_evt_o = evt_q;
    assign irq_o     = irq_q;
    assign dma_o     = dma_q;

    // R5
    dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suppress_i |=> (!evt_q && !dma_q));

    // R7
    ovf_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_only_i && !src_i.wrap) |=> !dma_q);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr_i) |=> irq_q);

    // R9
    dma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_q |-> irq_q);
endmodule

// File: rtl/tmr_update_ctrl.sv
// Timer update event controller top. It holds the enable bit and wires the
// prescaler, the counter and the update generator together. One-shot mode
// clears the enable bit by hardware on any update event.
// Assumes sw_ug and slv_restart are one-cycle pulses.
module tmr_update_ctrl
    import tmr_upd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             dir_down,
    input  logic [CNT_W-1:0] reload,
    input  logic [PSC_W-1:0] psc_div,
    input  logic             upd_suppress,
    input  logic             req_ovf_only,
    input  logic             one_shot,
    input  logic             sw_ug,
    input  logic             slv_restart,
    input  logic             irq_clr,
    output logic             timer_en,
    output logic [CNT_W-1:0] count,
    output logic             upd_evt,
    output logic             irq_flag,
    output logic             dma_req
);
    logic     en_q;
    logic     tick, wrap, reinit, upd_now, hw_clr;
    upd_src_t src;
    cnt_dir_e dir;

    assign dir    = cnt_dir_e'(dir_down);
    assign src    = '{wrap: wrap, sw: sw_ug, slv: slv_restart};
    // One-shot hardware clear of the enable bit.
    assign hw_clr = one_shot && upd_now;

    // Enable bit: any clear wins over a set.
    always_ff @(posedge clk) begin
        if (!rst_n)                en_q <= 1'b0;
        else if (en_clr || hw_clr) en_q <= 1'b0;
        else if (en_set)           en_q <= 1'b1;
    end

    tmr_psc #(.PSC_W(PSC_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (en_q),
        .reinit_i (reinit),
        .div_i    (psc_div),
        .tick_o   (tick)
    );

    tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .reinit_i (reinit),
        .dir_i    (dir),
        .reload_i (reload),
        .cnt_o    (count),
        .wrap_o   (wrap)
    );

    tmr_upd_gen u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src),
        .suppress_i (upd_suppress),
        .ovf_only_i (req_ovf_only),
        .irq_clr_i  (irq_clr),
        .upd_now_o  (upd_now),
        .reinit_o   (reinit),
        .upd_evt_o  (upd_evt),
        .irq_o      (irq_flag),
        .dma_o      (dma_req)
    );

    assign timer_en = en_q;

    // R10
    sp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (one_shot && upd_now) |=> !en_q);

    // R11
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !en_q);

    // R6
    reinit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (count == ($past(dir_down) ? $past(reload) : '0)));
endmodule

// File: tb/tmr_update_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench for the timer update event controller.
module tmr_update_ctrl_test;
    localparam int CW = 16;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_set = 0, en_clr = 0, dir_down = 0;
    logic [CW-1:0] reload = '0;
    logic [PW-1:0] psc_div = '0;
    logic          upd_suppress = 0, req_ovf_only = 0, one_shot = 0;
    logic          sw_ug = 0, slv_restart = 0, irq_clr = 0;
    logic          timer_en, upd_evt, irq_flag, dma_req;
    logic [CW-1:0] count;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tmr_update_ctrl #(.CNT_W(CW), .PSC_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .dir_down(dir_down), .reload(reload), .psc_div(psc_div),
        .upd_suppress(upd_suppress), .req_ovf_only(req_ovf_only),
        .one_shot(one_shot), .sw_ug(sw_ug), .slv_restart(slv_restart),
        .irq_clr(irq_clr), .timer_en(timer_en), .count(count),
        .upd_evt(upd_evt), .irq_flag(irq_flag), .dma_req(dma_req)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset and all controls back to defaults, ending at a negedge.
    task automatic do_reset();
        en_set = 0; en_clr = 0; dir_down = 0; reload = '0; psc_div = '0;
        upd_suppress = 0; req_ovf_only = 0; one_shot = 0;
        sw_ug = 0; slv_restart = 0; irq_clr = 0;
        rst_n = 0;
        cyc(3);
        rst_n = 1;
    endtask

    task automatic enable();
        en_set = 1; cyc(1); en_set = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "count", count, 0);
        chk("R1", "timer_en", timer_en, 0);
        chk("R1", "upd_evt", upd_evt, 0);
        chk("R1", "irq_flag", irq_flag, 0);
        chk("R1", "dma_req", dma_req, 0);
    endtask

    task automatic t_up();
        do_reset();
        reload = 5;
        enable();
        chk("R11", "timer_en after set", timer_en, 1);
        cyc(5);
        chk("R2", "count before wrap", count, 5);
        chk("R4", "no event before wrap", upd_evt, 0);
        cyc(1);
        chk("R2", "count after wrap", count, 0);
        chk("R4", "event on wrap", upd_evt, 1);
        chk("R7", "dma on wrap", dma_req, 1);
        chk("R7", "irq on wrap", irq_flag, 1);
        cyc(1);
        chk("R2", "count after wrap+1", count, 1);
        chk("R9", "dma one cycle", dma_req, 0);
        chk("R4", "event one cycle", upd_evt, 0);
        chk("R8", "irq sticky", irq_flag, 1);
        irq_clr = 1; cyc(1); irq_clr = 0;
        chk("R8", "irq cleared", irq_flag, 0);
    endtask

    task automatic t_psc();
        do_reset();
        reload = 10; psc_div = 2;
        enable();
        cyc(2);
        chk("R2", "no tick before ratio", count, 0);
        cyc(1);
        chk("R2", "first tick", count, 1);
        cyc(3);
        chk("R2", "second tick", count, 2);
    endtask

    task automatic t_down();
        do_reset();
        dir_down = 1; reload = 4;
        sw_ug = 1; cyc(1); sw_ug = 0;
        chk("R12", "sw_ug reinit while disabled", count, 4);
        chk("R4", "sw event", upd_evt, 1);
        chk("R7", "sw irq", irq_flag, 1);
        enable();
        chk("R12", "count held in enable cycle", count, 4);
        cyc(4);
        chk("R3", "count reached 0", count, 0);
        cyc(1);
        chk("R3", "underflow reload", count, 4);
        chk("R4", "underflow event", upd_evt, 1);
    endtask

    task automatic t_suppress();
        do_reset();
        upd_suppress = 1; reload = 3;
        enable();
        cyc(4);
        chk("R5", "wrap count", count, 0);
        chk("R5", "no event on wrap", upd_evt, 0);
        chk("R5", "no dma on wrap", dma_req, 0);
        chk("R5", "no irq on wrap", irq_flag, 0);
        cyc(2);
        chk("R2", "count 2", count, 2);
        psc_div = 3;
        cyc(2);
        chk("R2", "held by prescaler", count, 2);
        sw_ug = 1; cyc(1); sw_ug = 0;
        chk("R6", "sw reinit when suppressed", count, 0);
        chk("R5", "sw no event", upd_evt, 0);
        cyc(3);
        chk("R6", "prescaler restarted", count, 0);
        cyc(1);
        chk("R6", "tick after full ratio", count, 1);
        cyc(4);
        chk("R2", "count 2 again", count, 2);
        slv_restart = 1; cyc(1); slv_restart = 0;
        chk("R6", "slave reinit when suppressed", count, 0);
        chk("R5", "slave no event", upd_evt, 0);
        chk("R5", "irq still clear", irq_flag, 0);
    endtask

    task automatic t_ovf_only();
        do_reset();
        req_ovf_only = 1; reload = 2;
        sw_ug = 1; cyc(1); sw_ug = 0;
        chk("R7", "sw event silent", upd_evt, 1);
        chk("R7", "sw no dma", dma_req, 0);
        chk("R7", "sw no irq", irq_flag, 0);
        slv_restart = 1; cyc(1); slv_restart = 0;
        chk("R7", "slave event silent", upd_evt, 1);
        chk("R7", "slave no dma", dma_req, 0);
        chk("R7", "slave no irq", irq_flag, 0);
        enable();
        cyc(2);
        chk("R2", "count at limit", count, 2);
        cyc(1);
        chk("R7", "wrap dma", dma_req, 1);
        chk("R7", "wrap irq", irq_flag, 1);
    endtask

    task automatic t_slave();
        do_reset();
        dir_down = 1; reload = 7;
        slv_restart = 1; cyc(1); slv_restart = 0;
        chk("R6", "slave loads reload down", count, 7);
        chk("R4", "slave event", upd_evt, 1);
        chk("R9", "slave dma", dma_req, 1);
        // A request in the same cycle as the clear wins.
        irq_clr = 1; sw_ug = 1; cyc(1); irq_clr = 0; sw_ug = 0;
        chk("R8", "set wins over clear", irq_flag, 1);
    endtask

    task automatic t_one_shot();
        do_reset();
        one_shot = 1; reload = 3;
        enable();
        cyc(4);
        chk("R10", "count wrapped", count, 0);
        chk("R10", "enable cleared", timer_en, 0);
        chk("R10", "event raised", upd_evt, 1);
        cyc(3);
        chk("R10", "count halted", count, 0);
        enable();
        cyc(2);
        chk("R10", "restart after set", count, 2);
        sw_ug = 1; cyc(1); sw_ug = 0;
        chk("R10", "sw update stops timer", timer_en, 0);
        en_set = 1; upd_suppress = 0; sw_ug = 1; cyc(1); en_set = 0; sw_ug = 0;
        chk("R11", "hw clear wins over set", timer_en, 0);
    endtask

    task automatic t_enable();
        do_reset();
        reload = 20;
        enable();
        cyc(2);
        chk("R2", "count 2", count, 2);
        en_clr = 1; cyc(1); en_clr = 0;
        chk("R11", "enable cleared", timer_en, 0);
        chk("R12", "last step on clear edge", count, 3);
        cyc(3);
        chk("R12", "count holds disabled", count, 3);
        en_set = 1; en_clr = 1; cyc(1); en_set = 0; en_clr = 0;
        chk("R11", "clear wins over set", timer_en, 0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_up();
        t_psc();
        t_down();
        t_suppress();
        t_ovf_only();
        t_slave();
        t_one_shot();
        t_enable();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule